// File: doc/BRIEF.md
# Interlaced Half-Line Field Sequencer

This block produces the vertical timing of an interlaced picture. It counts half-lines across a frame made of two fields, an even field followed by an odd one. Each half-line is advanced by an external tick. The length of each field comes from a weighted sum of programmable timing counts: equalization, active video, and a pre- and post-blanking count. Each field has its own pre- and post-blanking pair.

On each tick the block reports several events with one-cycle strobes. These are the entry into the first or last half-line of a field, and the start of a new scan line. It also holds the identity of the current field and presents a vertical and a horizontal beam position. The horizontal position advances on a separate pixel tick and saturates at twice the programmed half-line width.

Timing values are loaded through a simple select/data write port. The field boundaries are recomputed from them into registers. This keeps the strobe comparison a plain equality against stored values rather than a long adder chain.

Top module: `halfline_field_seq`

## Requirements
- R1: A field lasts 3*EQ + PRE + 2*ACT + POST half-lines. The even field uses the even pre/post pair and the odd field uses the odd pair.
- R2: The even field begins at half-line 1 and the odd field at 1 + even length. On a tick entering either, `field_begin` pulses for one cycle with `begin_odd` = 1 for odd and 0 for even. `field_odd` then takes that value and holds it until the next begin.
- R3: Each tick moves `halfline` up by one. A tick taken at or beyond the last odd-field half-line (even length + odd length) returns it to 1. Without a tick, `halfline` does not change.
- R4: `field_end` pulses for one cycle on a tick entering half-line even length or half-line even length + odd length.
- R5: `line_start` pulses for one cycle on a tick entering an odd-numbered half-line.
- R6: `vpos` equals 1 + (halfline - 1)/2 with integer division.
- R7: `hpos` is 1 after reset and after each line start. Each `px_tick` raises it by one, up to a ceiling of 2*HW where it stays.
- R8: After reset: EQ=6, ACT=0, HW=429, odd PRE=502/POST=5, even PRE=503/POST=4. So both fields last 525 half-lines, `halfline` is 1, `field_odd` is 1 and all strobes are low.
- R9: `wr_sel` picks the target of a write: 0 EQ, 1 ACT, 2 odd PRE, 3 odd POST, 4 even PRE, 5 even POST, 6 HW. The value is taken from the low bits of `wr_data`. New boundaries apply to ticks two or more cycles after the write. A write never moves `halfline`, and a count beyond the new frame end wraps to 1 on the next tick.
- R10: A field whose sum is zero is treated as one half-line long, so the sequence never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Timing register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Write value |
| hl_tick | input | 1 | Advance one half-line |
| px_tick | input | 1 | Advance horizontal position |
| field_begin | output | 1 | First half-line of a field entered |
| begin_odd | output | 1 | Tag of the field just begun (1 = odd) |
| field_end | output | 1 | Last half-line of a field entered |
| field_odd | output | 1 | Current field identity |
| line_start | output | 1 | New scan line entered |
| halfline | output | CNT_W | Current 1-based half-line |
| vpos | output | CNT_W | Vertical beam position |
| hpos | output | LEN_W+1 | Horizontal beam position |

## Verification
The bench measures field lengths from the begin strobes for several register sets where the two fields differ. A design that swapped the even and odd blanking pairs, or weighted the sum wrongly, shows up as a length mismatch. The all-zero set and a set with only a zero even field target the length floor; without it the counter would stall or never emit an even-field end. It also shrinks the frame while the count lies far beyond the new end, which catches a wrap test written as equality. Finally it pushes the horizontal position past its ceiling and checks the odd-half-line parity that restarts it.

// File: rtl/halfline_field_seq.sv
module halfline_field_seq #(
  parameter int EQU_W = 4,
  parameter int LEN_W = 10,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [15:0]      wr_data,
  input  logic             hl_tick,
  input  logic             px_tick,
  output logic             field_begin,
  output logic             begin_odd,
  output logic             field_end,
  output logic             field_odd,
  output logic             line_start,
  output logic [CNT_W-1:0] halfline,
  output logic [CNT_W-1:0] vpos,
  output logic [LEN_W:0]   hpos
);

  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
  localparam int               RST_EVEN = 3*6 + 503 + 4;
  localparam int               RST_ODD  = 3*6 + 502 + 5;

  logic [EQU_W-1:0] equ_q;
  logic [LEN_W-1:0] act_q, opre_q, opost_q, epre_q, epost_q, hw_q;
  logic [CNT_W-1:0] even_len, odd_len;
  logic [CNT_W-1:0] odd_first_q, even_last_q, odd_last_q;
  logic [CNT_W-1:0] nxt;
  logic [LEN_W:0]   hlim;

  function automatic logic [CNT_W-1:0] fld_len(input logic [EQU_W-1:0] e,
                                               input logic [LEN_W-1:0] a,
                                               input logic [LEN_W-1:0] p,
                                               input logic [LEN_W-1:0] s);
    logic [CNT_W-1:0] raw;
    raw = CNT_W'(e) * CNT_W'(3) + CNT_W'(p) + CNT_W'(a) * CNT_W'(2) + CNT_W'(s);
    return (raw == '0) ? ONE : raw;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      equ_q   <= EQU_W'(6);
      act_q   <= '0;
      opre_q  <= LEN_W'(502);
      opost_q <= LEN_W'(5);
      epre_q  <= LEN_W'(503);
      epost_q <= LEN_W'(4);
      hw_q    <= LEN_W'(429);
    end else if (wr_en) begin
      case (wr_sel)
        3'd0: equ_q   <= wr_data[EQU_W-1:0];
        3'd1: act_q   <= wr_data[LEN_W-1:0];
        3'd2: opre_q  <= wr_data[LEN_W-1:0];
        3'd3: opost_q <= wr_data[LEN_W-1:0];
        3'd4: epre_q  <= wr_data[LEN_W-1:0];
        3'd5: epost_q <= wr_data[LEN_W-1:0];
        3'd6: hw_q    <= wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  assign even_len = fld_len(equ_q, act_q, epre_q, epost_q);
  assign odd_len  = fld_len(equ_q, act_q, opre_q, opost_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_last_q <= CNT_W'(RST_EVEN);
      odd_first_q <= CNT_W'(RST_EVEN + 1);
      odd_last_q  <= CNT_W'(RST_EVEN + RST_ODD);
    end else begin
      even_last_q <= even_len;
      odd_first_q <= even_len + ONE;
      odd_last_q  <= even_len + odd_len;
    end
  end

  assign nxt  = (halfline >= odd_last_q) ? ONE : halfline + ONE;
  assign vpos = (halfline + ONE) >> 1;
  assign hlim = {hw_q, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halfline    <= ONE;
      field_odd   <= 1'b1;
      field_begin <= 1'b0;
      begin_odd   <= 1'b0;
      field_end   <= 1'b0;
      line_start  <= 1'b0;
    end else begin
      field_begin <= 1'b0;
      field_end   <= 1'b0;
      line_start  <= 1'b0;
      if (hl_tick) begin
        halfline   <= nxt;
        line_start <= nxt[0];
        field_end  <= (nxt == even_last_q) || (nxt == odd_last_q);
        if (nxt == ONE || nxt == odd_first_q) begin
          field_begin <= 1'b1;
          begin_odd   <= (nxt == odd_first_q);
          field_odd   <= (nxt == odd_first_q);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hpos <= (LEN_W+1)'(1);
    else if (hl_tick && nxt[0])
      hpos <= (LEN_W+1)'(1);
    else if (px_tick && hpos < hlim)
      hpos <= hpos + (LEN_W+1)'(1);
  end

  p_begin_tag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    field_begin |-> (field_odd == begin_odd));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hl_tick && halfline >= odd_last_q) |=> (halfline == ONE));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hl_tick |=> $stable(halfline));

  p_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halfline != '0);

  p_line_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> halfline[0]);

  p_hpos_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hpos != '0);

endmodule

// File: tb/tb_halfline_field_seq.sv
module tb_halfline_field_seq;
  localparam int CNT_W = 14;
  localparam int LEN_W = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, hl_tick = 0, px_tick = 0;
  logic [2:0] wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic field_begin, begin_odd, field_end, field_odd, line_start;
  logic [CNT_W-1:0] halfline, vpos;
  logic [LEN_W:0] hpos;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  halfline_field_seq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .hl_tick(hl_tick), .px_tick(px_tick), .field_begin(field_begin),
    .begin_odd(begin_odd), .field_end(field_end), .field_odd(field_odd),
    .line_start(line_start), .halfline(halfline), .vpos(vpos), .hpos(hpos));

  // {eq, act, odd pre, odd post, even pre, even post}
  localparam logic [59:0] CFG [5] = '{
    {10'd1, 10'd2, 10'd3, 10'd4, 10'd2, 10'd2},
    {10'd0, 10'd0, 10'd5, 10'd0, 10'd0, 10'd3},
    {10'd2, 10'd1, 10'd0, 10'd0, 10'd1, 10'd0},
    {10'd0, 10'd0, 10'd0, 10'd0, 10'd0, 10'd0},
    {10'd0, 10'd0, 10'd2, 10'd0, 10'd0, 10'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) hl_tick = 1;
    @(negedge clk) hl_tick = 0;
  endtask

  task automatic px(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) px_tick = 1;
      @(negedge clk) px_tick = 0;
    end
  endtask

  task automatic wr(input int sel, input int val);
    @(negedge clk) begin wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(val); end
    @(negedge clk) wr_en = 0;
    @(negedge clk);
  endtask

  function automatic int flen(input int e, input int a, input int p, input int s);
    int r;
    r = 3*e + p + 2*a + s;
    return (r == 0) ? 1 : r;
  endfunction

  // from a begin sample, tick until begin of field tagged want; returns length and end position
  task automatic measure(input logic want, output int len, output int endpos);
    endpos = field_end ? 0 : -1;
    len = 0;
    for (int g = 0; g < 5000; g++) begin
      tick();
      len++;
      if (field_begin && begin_odd == want) break;
      if (field_end) endpos = len;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n, first_end, len, ep;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 halfline", int'(halfline), 1);
    chk("R8 field_odd", int'(field_odd), 1);
    chk("R8 strobes", int'({field_begin, field_end, line_start}), 0);
    chk("R7 hpos reset", int'(hpos), 1);
    rst_n = 1;
    @(negedge clk);

    // R8/R2/R4 default even field length 525
    n = 0; first_end = -1;
    for (int g = 0; g < 2000; g++) begin
      tick(); n++;
      if (field_end && first_end < 0) first_end = n;
      if (field_begin) break;
    end
    chk("R8 default even length", n, 525);
    chk("R2 odd begin tag", int'(begin_odd), 1);
    chk("R2 field_odd after odd begin", int'(field_odd), 1);
    chk("R4 even end position", first_end, 524);
    chk("R6 vpos at 526", int'(vpos), 263);
    tick();
    chk("R3 halfline advance", int'(halfline), 527);
    chk("R6 vpos at 527", int'(vpos), 264);
    chk("R5 line start on odd", int'(line_start), 1);
    tick();
    chk("R5 no line start on even", int'(line_start), 0);
    chk("R6 vpos at 528", int'(vpos), 264);

    // R7 horizontal clamp with HW=3
    wr(6, 3);
    chk("R9 write keeps halfline", int'(halfline), 528);
    px(10);
    chk("R7 hpos clamp", int'(hpos), 6);
    tick();
    chk("R7 hpos restart at line", int'(hpos), 1);
    px(2);
    chk("R7 hpos count", int'(hpos), 3);
    repeat (5) @(negedge clk);
    chk("R3 hold without tick", int'(halfline), 529);

    // R1/R9/R10 table walk
    for (int k = 0; k < 5; k++) begin
      int e, a, op, os, ep2, es, xe, xo;
      e = int'(CFG[k][59:50]); a = int'(CFG[k][49:40]);
      op = int'(CFG[k][39:30]); os = int'(CFG[k][29:20]);
      ep2 = int'(CFG[k][19:10]); es = int'(CFG[k][9:0]);
      wr(0, e); wr(1, a); wr(2, op); wr(3, os); wr(4, ep2); wr(5, es);
      xe = flen(e, a, ep2, es); xo = flen(e, a, op, os);
      if (k == 0) begin
        tick();
        chk("R9 shrink wraps to 1", int'(halfline), 1);
        chk("R2 even begin on wrap", int'(field_begin && !begin_odd), 1);
      end else begin
        for (int g = 0; g < 5000; g++) begin
          tick();
          if (field_begin && !begin_odd) break;
        end
      end
      chk("R2 field_odd even", int'(field_odd), 0);
      measure(1'b1, len, ep);
      chk($sformatf("R1 even length cfg%0d", k), len, xe);
      chk($sformatf("R4 even end cfg%0d", k), ep, xe - 1);
      measure(1'b0, len, ep);
      chk($sformatf("R1 odd length cfg%0d", k), len, xo);
      chk($sformatf("R4 odd end cfg%0d", k), ep, xo - 1);
      if (k == 3) chk("R10 zero fields length one", len, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule